// File: doc/BRIEF.md
# Cartridge Program-Bank Controller

This block sits on the processor bus of a cartridge and turns processor writes in the upper half of the address space into bank selections. It holds a 16 KB program bank, an 8 KB program bank, an 8-bit banking-mode word and eight 1 KB pattern-bank words. From these it builds the program ROM address for every processor read above 0x8000. It also decides whether the work RAM window at 0x6000–0x7FFF answers.

Writes that belong to the sound generator or to the interrupt counter are not handled here. They are passed on as registered one-cycle strobes on plain output pins, because neither engine has a back-pressure path. The pattern words and the mode word go out as plain level outputs to the video-side mapper. A strap input swaps address bits 0 and 1 before decoding, so that one netlist serves both board wirings.

Top module: `cart_bank_ctrl`

## Requirements
- R1: Only address bits 15:12 and 1:0 take part in register decode; bits 11:2 are ignored (0xD7FE selects the same register as 0xD002).
- R2: When `swap_a01` is 1, address bits 0 and 1 are exchanged before decode, and the exchanged address is the one reported on `snd_addr`.
- R3: A write to 0x8000–0x8003 stores data[3:0] as B. A read at 0x8000–0x9FFF then maps to page 2·B, and a read at 0xA000–0xBFFF maps to page 2·B+1.
- R4: A write to 0xC000–0xC003 stores data[4:0] as the page for reads at 0xC000–0xDFFF.
- R5: Reads at 0xE000–0xFFFF always map to page PRG_PAGES−1. `prg_addr` is {page, cpu_addr[12:0]}, and `prg_sel` equals cpu_addr[15].
- R6: A write to 0xB003 loads `mode` with the data byte. `ram_sel` is 1 only when cpu_addr is in 0x6000–0x7FFF and mode bit 7 is 1.
- R7: A write to 0xD000+k loads pattern word k, and a write to 0xE000+k loads word 4+k (k = 0..3). Word j appears on `pat_banks[8j+7:8j]`.
- R8: Writes to 0x9000–0x9003, 0xA000–0xA002 and 0xB000–0xB002 produce, on the next cycle, a one-cycle `snd_wr` pulse with the masked address and the data. A write to 0xA003 or 0xB003 produces no pulse.
- R9: Writes to 0xF000, 0xF001 and 0xF002 produce, on the next cycle, a one-cycle pulse on `irq_reload`, `irq_ctrl` or `irq_ack` respectively, with the data on `irq_data`. 0xF003 produces nothing.
- R10: After reset, the mode word, both program banks and all pattern words are 0, no strobe is active, and the RAM window is closed.
- R11: When `cpu_wr` is 0, and for addresses below 0x8000, no register changes and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_a01 | input | 1 | Board strap: exchange address bits 0 and 1 before decode |
| cpu_wr | input | 1 | Processor write qualifier for this cycle |
| cpu_addr | input | 16 | Processor address, used for both writes and reads |
| cpu_data | input | 8 | Processor write data |
| prg_addr | output | PAGE_W+13 | Program ROM byte address |
| prg_sel | output | 1 | Program ROM selected (address at or above 0x8000) |
| ram_sel | output | 1 | Work RAM window selected and enabled |
| mode | output | 8 | Banking-mode word for the video-side mapper |
| pat_banks | output | 64 | Eight pattern-bank words, word j in bits 8j+7:8j |
| snd_wr | output | 1 | One-cycle sound register write strobe |
| snd_addr | output | 16 | Masked, strap-adjusted address of the sound write |
| snd_data | output | 8 | Sound write data |
| irq_reload | output | 1 | Interrupt reload-value write strobe |
| irq_ctrl | output | 1 | Interrupt control write strobe |
| irq_ack | output | 1 | Interrupt acknowledge strobe |
| irq_data | output | 8 | Interrupt write data |

## Verification
The assertions assume that `cpu_wr` describes a single write per cycle, with the address and data held steady around the sampling edge. They also assume that `swap_a01` is tied for long stretches, not toggled in the same cycle as a write it should affect. The bench drives every input on the falling edge and changes the strap only between write cycles. It expects each sound or interrupt event in the cycle after its write, and it reads the program mapping combinationally by presenting read addresses with `cpu_wr` low.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  typedef enum logic [3:0] {
    TGT_NONE,
    TGT_PRG16,
    TGT_PRG8,
    TGT_MODE,
    TGT_PAT_LO,
    TGT_PAT_HI,
    TGT_SOUND,
    TGT_IRQ_RELOAD,
    TGT_IRQ_CTRL,
    TGT_IRQ_ACK
  } wr_target_e;

  // exchange address bits 0 and 1 for the alternate board wiring
  function automatic logic [15:0] swap_low_bits(input logic [15:0] a);
    return {a[15:2], a[0], a[1]};
  endfunction

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cart_bank_pkg::*;
(
  input  logic        swap_a01,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  output wr_target_e  target,
  output logic [1:0]  sub_idx,
  output logic [15:0] key_addr
);

  logic [15:0] eff_addr;

  always_comb begin
    eff_addr = swap_a01 ? swap_low_bits(cpu_addr) : cpu_addr;
    key_addr = eff_addr & 16'hF003;
    sub_idx  = key_addr[1:0];
  end

  always_comb begin
    target = TGT_NONE;
    if (cpu_wr) begin
      unique case (key_addr[15:12])
        4'h8: target = TGT_PRG16;
        4'h9: target = TGT_SOUND;
        4'hA: target = (sub_idx == 2'd3) ? TGT_NONE : TGT_SOUND;
        4'hB: target = (sub_idx == 2'd3) ? TGT_MODE : TGT_SOUND;
        4'hC: target = TGT_PRG8;
        4'hD: target = TGT_PAT_LO;
        4'hE: target = TGT_PAT_HI;
        4'hF: begin
          unique case (sub_idx)
            2'd0: target = TGT_IRQ_RELOAD;
            2'd1: target = TGT_IRQ_CTRL;
            2'd2: target = TGT_IRQ_ACK;
            default: target = TGT_NONE;
          endcase
        end
        default: target = TGT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
  import cart_bank_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PAT_GRP  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  wr_target_e                    target,
  input  logic [1:0]                    sub_idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [3:0]                    bank16,
  output logic [4:0]                    bank8,
  output logic [DATA_W-1:0]             mode_q,
  output logic [2*PAT_GRP*DATA_W-1:0]   pat_flat
);

  localparam int NPAT = 2 * PAT_GRP;

  logic [NPAT-1:0][DATA_W-1:0] pat_q;
  logic mode_we;

  assign mode_we = (target == TGT_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank16 <= '0;
      bank8  <= '0;
      mode_q <= '0;
    end else begin
      if (target == TGT_PRG16) bank16 <= wr_data[3:0];
      if (target == TGT_PRG8)  bank8  <= wr_data[4:0];
      if (mode_we)             mode_q <= wr_data;
    end
  end

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    localparam wr_target_e GRP_TGT = (g < PAT_GRP) ? TGT_PAT_LO : TGT_PAT_HI;
    localparam int         SLOT    = g % PAT_GRP;
    always_ff @(posedge clk) begin
      if (!rst_n)
        pat_q[g] <= '0;
      else if (target == GRP_TGT && int'(sub_idx) == SLOT)
        pat_q[g] <= wr_data;
    end
  end

  assign pat_flat = pat_q;

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_we) |-> $stable(mode_q));

  // R7
  pat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(target == TGT_PAT_LO || target == TGT_PAT_HI) |-> $stable(pat_q));

endmodule

// File: rtl/cbc_events.sv
module cbc_events
  import cart_bank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_target_e        target,
  input  logic [15:0]       key_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              snd_wr,
  output logic [15:0]       snd_addr,
  output logic [DATA_W-1:0] snd_data,
  output logic              irq_reload,
  output logic              irq_ctrl,
  output logic              irq_ack,
  output logic [DATA_W-1:0] irq_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snd_wr     <= 1'b0;
      snd_addr   <= '0;
      snd_data   <= '0;
      irq_reload <= 1'b0;
      irq_ctrl   <= 1'b0;
      irq_ack    <= 1'b0;
      irq_data   <= '0;
    end else begin
      snd_wr     <= (target == TGT_SOUND);
      irq_reload <= (target == TGT_IRQ_RELOAD);
      irq_ctrl   <= (target == TGT_IRQ_CTRL);
      irq_ack    <= (target == TGT_IRQ_ACK);
      if (target == TGT_SOUND) begin
        snd_addr <= key_addr;
        snd_data <= wr_data;
      end
      if (target inside {TGT_IRQ_RELOAD, TGT_IRQ_CTRL, TGT_IRQ_ACK})
        irq_data <= wr_data;
    end
  end

  // R9
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_reload, irq_ctrl, irq_ack, snd_wr}));

endmodule

// File: rtl/cbc_map.sv
module cbc_map #(
  parameter int PRG_PAGES = 32,
  parameter int PAGE_W    = 5
) (
  input  logic [15:0]         cpu_addr,
  input  logic [3:0]          bank16,
  input  logic [4:0]          bank8,
  input  logic                ram_en,
  output logic [PAGE_W+12:0]  prg_addr,
  output logic                prg_sel,
  output logic                ram_sel
);

  localparam logic [7:0] LAST_PAGE = 8'(PRG_PAGES - 1);

  logic [7:0] page8;

  always_comb begin
    unique case (cpu_addr[14:13])
      2'd0:    page8 = {3'b000, bank16, 1'b0};
      2'd1:    page8 = {3'b000, bank16, 1'b1};
      2'd2:    page8 = {3'b000, bank8};
      default: page8 = LAST_PAGE;
    endcase
  end

  assign prg_addr = {page8[PAGE_W-1:0], cpu_addr[12:0]};
  assign prg_sel  = cpu_addr[15];
  assign ram_sel  = ram_en && (cpu_addr[15:13] == 3'b011);

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int PRG_PAGES = 32,
  localparam int PAGE_W   = $clog2(PRG_PAGES),
  localparam int DATA_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 swap_a01,
  input  logic                 cpu_wr,
  input  logic [15:0]          cpu_addr,
  input  logic [DATA_W-1:0]    cpu_data,
  output logic [PAGE_W+12:0]   prg_addr,
  output logic                 prg_sel,
  output logic                 ram_sel,
  output logic [DATA_W-1:0]    mode,
  output logic [8*DATA_W-1:0]  pat_banks,
  output logic                 snd_wr,
  output logic [15:0]          snd_addr,
  output logic [DATA_W-1:0]    snd_data,
  output logic                 irq_reload,
  output logic                 irq_ctrl,
  output logic                 irq_ack,
  output logic [DATA_W-1:0]    irq_data
);

  wr_target_e  target;
  logic [1:0]  sub_idx;
  logic [15:0] key_addr;
  logic [3:0]  bank16;
  logic [4:0]  bank8;

  cbc_decode u_decode (
    .swap_a01 (swap_a01),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .target   (target),
    .sub_idx  (sub_idx),
    .key_addr (key_addr)
  );

  cbc_regs #(.DATA_W(DATA_W), .PAT_GRP(4)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .target   (target),
    .sub_idx  (sub_idx),
    .wr_data  (cpu_data),
    .bank16   (bank16),
    .bank8    (bank8),
    .mode_q   (mode),
    .pat_flat (pat_banks)
  );

  cbc_events #(.DATA_W(DATA_W)) u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .target     (target),
    .key_addr   (key_addr),
    .wr_data    (cpu_data),
    .snd_wr     (snd_wr),
    .snd_addr   (snd_addr),
    .snd_data   (snd_data),
    .irq_reload (irq_reload),
    .irq_ctrl   (irq_ctrl),
    .irq_ack    (irq_ack),
    .irq_data   (irq_data)
  );

  cbc_map #(.PRG_PAGES(PRG_PAGES), .PAGE_W(PAGE_W)) u_map (
    .cpu_addr (cpu_addr),
    .bank16   (bank16),
    .bank8    (bank8),
    .ram_en   (mode[7]),
    .prg_addr (prg_addr),
    .prg_sel  (prg_sel),
    .ram_sel  (ram_sel)
  );

  // R8
  snd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_wr |-> $past(cpu_wr && cpu_addr[15]));

  // R9
  irq_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reload || irq_ctrl || irq_ack) |-> $past(cpu_wr && cpu_addr[15:12] == 4'hF));

  // R6
  ram_rom_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_sel && prg_sel));

endmodule

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;

  localparam int PRG_PAGES = 32;
  localparam int PAGE_W    = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swap_a01 = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic [PAGE_W+12:0] prg_addr;
  logic        prg_sel, ram_sel;
  logic [7:0]  mode;
  logic [63:0] pat_banks;
  logic        snd_wr;
  logic [15:0] snd_addr;
  logic [7:0]  snd_data;
  logic        irq_reload, irq_ctrl, irq_ack;
  logic [7:0]  irq_data;

  always #5 clk = ~clk;

  cart_bank_ctrl #(.PRG_PAGES(PRG_PAGES)) i_cart_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .swap_a01(swap_a01), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .prg_addr(prg_addr),
    .prg_sel(prg_sel), .ram_sel(ram_sel), .mode(mode), .pat_banks(pat_banks),
    .snd_wr(snd_wr), .snd_addr(snd_addr), .snd_data(snd_data),
    .irq_reload(irq_reload), .irq_ctrl(irq_ctrl), .irq_ack(irq_ack),
    .irq_data(irq_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit monitor_on = 1'b0;

  // event kinds: 0 sound, 1 reload, 2 control, 3 acknowledge
  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  data;
  } evt_t;

  evt_t exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_evt(input logic [1:0] kind, input logic [15:0] addr, input logic [7:0] data);
    evt_t e;
    e.kind = kind; e.addr = addr; e.data = data;
    exp_q.push_back(e);
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 16'h0000;
  endtask

  function automatic logic [PAGE_W+12:0] rom_of(input int page, input logic [15:0] a);
    return {page[PAGE_W-1:0], a[12:0]};
  endfunction

  task automatic read_map(input string req, input logic [15:0] a, input int page);
    @(negedge clk);
    cpu_addr = a;
    #1;
    chk(req, 32'(prg_addr), 32'(rom_of(page, a)));
  endtask

  // scoreboard monitor: every strobe seen must match the head of the queue
  always @(negedge clk) begin
    if (monitor_on) begin
      int ns;
      evt_t got;
      ns = int'(snd_wr) + int'(irq_reload) + int'(irq_ctrl) + int'(irq_ack);
      if (ns > 1) begin
        n_checks++; n_fail++;
        $display("FAIL R9 actual=%0d strobes expected=1", ns);
      end else if (ns == 1) begin
        got.kind = snd_wr ? 2'd0 : irq_reload ? 2'd1 : irq_ctrl ? 2'd2 : 2'd3;
        got.addr = snd_wr ? snd_addr : 16'h0000;
        got.data = snd_wr ? snd_data : irq_data;
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R8/R9/R11 actual=%h expected=no event", got);
        end else begin
          chk("R8/R9 event", 32'(got), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    monitor_on = 1'b1;

    // R10 reset state
    @(negedge clk); cpu_addr = 16'h6000; #1;
    chk("R10 ram closed", 32'(ram_sel), 0);
    chk("R10 mode", 32'(mode), 0);
    chk("R10 patterns", 32'(pat_banks[31:0] | pat_banks[63:32]), 0);
    read_map("R10 bank16", 16'h8000, 0);
    read_map("R10 bank8", 16'hC000, 0);
    read_map("R5 fixed top", 16'hE123, PRG_PAGES - 1);
    #1; chk("R5 prg_sel", 32'(prg_sel), 1);

    // R3 16 KB bank
    cpu_write(16'h8002, 8'h37);
    read_map("R3 low half", 16'h8456, 14);
    read_map("R3 high half", 16'hA123, 15);

    // R4 and R1: 0xC3F1 masks to 0xC001
    cpu_write(16'hC3F1, 8'h3B);
    read_map("R4 R1 bank8", 16'hC0FF, 27);
    read_map("R5 still fixed", 16'hFFFF, PRG_PAGES - 1);

    // R6 mode and RAM window
    cpu_write(16'hB003, 8'h80);
    chk("R6 mode", 32'(mode), 32'h80);
    @(negedge clk); cpu_addr = 16'h6ABC; #1;
    chk("R6 ram open", 32'(ram_sel), 1);
    @(negedge clk); cpu_addr = 16'h5FFF; #1;
    chk("R6 below window", 32'(ram_sel), 0);
    @(negedge clk); cpu_addr = 16'h8000; #1;
    chk("R6 above window", 32'(ram_sel), 0);

    // R11 write strobe low: mode keeps 0x80
    @(negedge clk); cpu_addr = 16'hB003; cpu_data = 8'h11; cpu_wr = 1'b0;
    @(negedge clk); cpu_addr = 16'h0000;
    chk("R11 no write", 32'(mode), 32'h80);
    cpu_write(16'h7000, 8'hFF);
    cpu_write(16'h4003, 8'hFF);
    chk("R11 low address", 32'(mode), 32'h80);

    cpu_write(16'hB003, 8'h7F);
    @(negedge clk); cpu_addr = 16'h7FFF; #1;
    chk("R6 ram closed", 32'(ram_sel), 0);

    // R7 pattern words
    for (int k = 0; k < 4; k++) cpu_write(16'hD000 + 16'(k), 8'h10 + 8'(k));
    for (int k = 0; k < 4; k++) cpu_write(16'hE7FC + 16'(k), 8'hA0 + 8'(k));
    chk("R7 low group", 32'(pat_banks[31:0]), 32'h13121110);
    chk("R7 high group", 32'(pat_banks[63:32]), 32'hA3A2A1A0);

    // R8 sound forwarding
    expect_evt(2'd0, 16'h9000, 8'h55); cpu_write(16'h9000, 8'h55);
    expect_evt(2'd0, 16'hA002, 8'h66); cpu_write(16'hA002, 8'h66);
    expect_evt(2'd0, 16'hB001, 8'h77); cpu_write(16'hB0F1, 8'h77);
    cpu_write(16'hA003, 8'h88);
    expect_evt(2'd0, 16'h9003, 8'h99); cpu_write(16'h9003, 8'h99);

    // R9 interrupt strobes
    expect_evt(2'd1, 16'h0000, 8'hC1); cpu_write(16'hF000, 8'hC1);
    expect_evt(2'd2, 16'h0000, 8'hC2); cpu_write(16'hF001, 8'hC2);
    expect_evt(2'd3, 16'h0000, 8'hC3); cpu_write(16'hF002, 8'hC3);
    cpu_write(16'hF003, 8'hC4);

    // R2 strap swaps bits 0 and 1
    @(negedge clk); swap_a01 = 1'b1;
    expect_evt(2'd0, 16'hB002, 8'h21); cpu_write(16'hB001, 8'h21);
    expect_evt(2'd0, 16'hB001, 8'h22); cpu_write(16'hB002, 8'h22);
    expect_evt(2'd3, 16'h0000, 8'h23); cpu_write(16'hF001, 8'h23);
    cpu_write(16'hD001, 8'h5A);
    chk("R2 pattern slot", 32'(pat_banks[23:16]), 32'h5A);
    chk("R2 other slot", 32'(pat_banks[15:8]), 32'h11);
    cpu_write(16'hB003, 8'h81);
    chk("R2 mode reg", 32'(mode), 32'h81);
    @(negedge clk); swap_a01 = 1'b0;

    repeat (3) @(negedge clk);
    chk("R8/R9 queue drained", 32'(exp_q.size()), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule